// File: doc/BRIEF.md
# Host Register Access Bridge

This block sits between a host-side register access path and an on-chip AXI4-Lite register fabric. Each host request carries a read or write flag, a byte offset, a byte length, a tag and, for writes, a data word. Requests enter through a short queue with valid/ready flow control. They are then served strictly in arrival order.

Offsets below a low window limit are answered at once from a built-in read-only identification window, and no bus traffic is generated for them. All other offsets are forwarded as single AXI4-Lite transactions, with only one transaction in flight at a time. Every request, read or write, produces exactly one completion on a valid/ready output. A completion carries the request tag, the read data trimmed to the requested byte length, and the response code.

Top module: `mmio_axil_bridge`

## Requirements
- R1: A read whose offset is below 0x80000 completes with a fixed identification value, and no valid is raised on any AXI-Lite channel. The values are: 0x00 gives 32, 0x04 gives 1, 0x08 gives 0x43215678, 0x0C gives 1, 0x10 gives 1, 0x14 gives 0x200, 0x18 gives 0x80, 0x20 gives 1, 0x24 gives 0x80000 and 0x2C gives 0x80000. The response code is 0.
- R2: A read below 0x80000 at any offset not listed in R1 completes with data 0 and response code 0.
- R3: Read completion data is trimmed by the request length field. A length of 1, 2 or 3 keeps that many low-order bytes and clears the bytes above them. Any other length value keeps all four bytes. This applies to both local and forwarded reads.
- R4: A write below 0x80000 causes no AXI-Lite traffic and leaves the window values unchanged. It completes with the write flag set, data 0 and response code 0.
- R5: A read at offset 0x80000 or above raises ARVALID with RREADY in the same cycle, with ARADDR equal to the offset and ARPROT equal to 0. ARVALID and ARADDR are held until ARREADY, and ARVALID drops in the cycle after the address handshake. The completion returns the tag, the trimmed RDATA and the RRESP value.
- R6: A write at offset 0x80000 or above raises AWVALID and WVALID together, with AWADDR equal to the offset, WDATA equal to the request data, WSTRB equal to 0xF and AWPROT equal to 0. Each valid drops in the cycle after its own handshake. BREADY rises only after both handshakes are done. The completion carries the write flag, the tag, data 0 and the BVALID-cycle BRESP.
- R7: At most one forwarded transaction is active. Read channel signals (ARVALID, RREADY) are never high while any write channel signal (AWVALID, WVALID, BREADY) is high. Completions leave in request order.
- R8: While the completion output is valid and not accepted, it stays valid and all of its fields stay unchanged.
- R9: The request input deasserts ready once the queue holds FIFO_DEPTH requests that have not yet been served.
- R10: During and right after reset, the queue is empty (request ready high) and no completion is valid. ARVALID, RREADY, AWVALID, WVALID and BREADY are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | 24 | Byte offset of the access |
| req_len | input | 3 | Byte length of the access |
| req_tag | input | 8 | Tag echoed in the completion |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | Completion available |
| cpl_ready | input | 1 | Completion accepted |
| cpl_write | output | 1 | Completion belongs to a write |
| cpl_tag | output | 8 | Tag of the completed request |
| cpl_data | output | 32 | Read data (0 for writes) |
| cpl_resp | output | 2 | Response code |
| m_awaddr | output | 24 | Write address |
| m_awprot | output | 3 | Write protection, always 0 |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 24 | Read address |
| m_arprot | output | 3 | Read protection, always 0 |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
A stuck phase flag in the forwarding engine shows within one cycle as a valid that stays high after its handshake. It also shows as read and write channel signals high together, or as BREADY rising while AWVALID or WVALID is still up. A wrong queue pointer or count shows at the next completion as a wrong tag or a reordering, or as request ready at the wrong level when the queue is full. A wrong window decode or a wrong length mask shows in the data of the first completion that depends on it. A bus transaction issued for a local offset shows as an unexpected address handshake.

// File: rtl/mmio_bridge_pkg.sv
package mmio_bridge_pkg;

    localparam int OFS_W  = 24;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 3;
    localparam int STRB_W = DATA_W / 8;
    localparam int RESP_W = 2;
    localparam int PROT_W = 3;

    typedef struct packed {
        logic              wr;
        logic [OFS_W-1:0]  ofs;
        logic [LEN_W-1:0]  len;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic              wr;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
        logic [RESP_W-1:0] resp;
    } cpl_t;

    // Fixed identification window contents.
    function automatic logic [DATA_W-1:0] id_value(input logic [OFS_W-1:0] ofs);
        case (ofs)
            24'h00:  return 32'd32;
            24'h04:  return 32'd1;
            24'h08:  return 32'h4321_5678;
            24'h0C:  return 32'd1;
            24'h10:  return 32'd1;
            24'h14:  return 32'h200;
            24'h18:  return 32'h80;
            24'h20:  return 32'd1;
            24'h24:  return 32'h8_0000;
            24'h2C:  return 32'h8_0000;
            default: return '0;
        endcase
    endfunction

    // Keep the low len bytes; 1..3 trim, other values keep the full word.
    function automatic logic [DATA_W-1:0] len_mask(input logic [DATA_W-1:0] d,
                                                   input logic [LEN_W-1:0]  len);
        logic [DATA_W-1:0] m;
        m = '1;
        if (len != '0 && int'(len) < STRB_W)
            m = ~({DATA_W{1'b1}} << (8 * int'(len)));
        return d & m;
    endfunction

endpackage

// File: rtl/mmio_req_fifo.sv
module mmio_req_fifo
    import mmio_bridge_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push_valid,
    output logic push_ready,
    input  req_t push_data,
    output logic pop_valid,
    input  logic pop_ready,
    output req_t pop_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    req_t             slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_fire, pop_fire;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ready = (count != CNT_W'(DEPTH));
    assign pop_valid  = (count != '0);
    assign pop_data   = slots[rd_ptr];
    assign push_fire  = push_valid && push_ready;
    assign pop_fire   = pop_valid && pop_ready;

    always_ff @(posedge clk) begin
        if (push_fire) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_fire) wr_ptr <= bump(wr_ptr);
            if (pop_fire)  rd_ptr <= bump(rd_ptr);
            case ({push_fire, pop_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/mmio_id_window.sv
module mmio_id_window
    import mmio_bridge_pkg::*;
#(
    parameter logic [OFS_W-1:0] LIMIT = 24'h8_0000
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [LEN_W-1:0]  len,
    output logic              hit,
    output logic [DATA_W-1:0] word
);
    assign hit  = (ofs < LIMIT);
    assign word = len_mask(id_value(ofs), len);
endmodule

// File: rtl/mmio_axil_engine.sv
module mmio_axil_engine
    import mmio_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  req_t              start_req,
    output logic              busy,
    output logic              done,
    output cpl_t              done_cpl,
    output logic [OFS_W-1:0]  m_awaddr,
    output logic [PROT_W-1:0] m_awprot,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [RESP_W-1:0] m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [OFS_W-1:0]  m_araddr,
    output logic [PROT_W-1:0] m_arprot,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [RESP_W-1:0] m_rresp,
    input  logic              m_rvalid,
    output logic              m_rready
);
    // Phase flags: each one is a bus valid/ready output.
    logic              aw_pend, w_pend, b_wait, ar_pend, r_wait;
    logic [OFS_W-1:0]  addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LEN_W-1:0]  len_q;
    logic              aw_left, w_left, rd_done, wr_done;

    assign aw_left = aw_pend && !m_awready;
    assign w_left  = w_pend  && !m_wready;
    assign rd_done = r_wait && m_rvalid;
    assign wr_done = b_wait && m_bvalid;

    assign busy = aw_pend | w_pend | b_wait | ar_pend | r_wait;
    assign done = rd_done | wr_done;

    always_comb begin
        done_cpl      = '0;
        done_cpl.wr   = b_wait;
        done_cpl.tag  = tag_q;
        done_cpl.data = b_wait ? '0 : len_mask(m_rdata, len_q);
        done_cpl.resp = b_wait ? m_bresp : m_rresp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_pend <= 1'b0;
            w_pend  <= 1'b0;
            b_wait  <= 1'b0;
            ar_pend <= 1'b0;
            r_wait  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            tag_q   <= '0;
            len_q   <= '0;
        end else if (start) begin
            addr_q  <= start_req.ofs;
            wdata_q <= start_req.wdata;
            tag_q   <= start_req.tag;
            len_q   <= start_req.len;
            aw_pend <= start_req.wr;
            w_pend  <= start_req.wr;
            ar_pend <= !start_req.wr;
            r_wait  <= !start_req.wr;
        end else begin
            if (aw_pend && m_awready) aw_pend <= 1'b0;
            if (w_pend && m_wready)   w_pend  <= 1'b0;
            if ((aw_pend || w_pend) && !aw_left && !w_left) b_wait <= 1'b1;
            if (wr_done)              b_wait  <= 1'b0;
            if (ar_pend && m_arready) ar_pend <= 1'b0;
            if (rd_done)              r_wait  <= 1'b0;
        end
    end

    assign m_awaddr  = addr_q;
    assign m_araddr  = addr_q;
    assign m_awprot  = '0;
    assign m_arprot  = '0;
    assign m_wdata   = wdata_q;
    assign m_wstrb   = '1;
    assign m_awvalid = aw_pend;
    assign m_wvalid  = w_pend;
    assign m_bready  = b_wait;
    assign m_arvalid = ar_pend;
    assign m_rready  = r_wait;

endmodule

// File: rtl/mmio_axil_bridge.sv
module mmio_axil_bridge
    import mmio_bridge_pkg::*;
#(
    parameter int               FIFO_DEPTH  = 4,
    parameter logic [OFS_W-1:0] LOCAL_LIMIT = 24'h8_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic              cpl_write,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [DATA_W-1:0] cpl_data,
    output logic [RESP_W-1:0] cpl_resp,
    output logic [OFS_W-1:0]  m_awaddr,
    output logic [PROT_W-1:0] m_awprot,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [RESP_W-1:0] m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [OFS_W-1:0]  m_araddr,
    output logic [PROT_W-1:0] m_arprot,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [RESP_W-1:0] m_rresp,
    input  logic              m_rvalid,
    output logic              m_rready
);
    req_t              in_req, head;
    logic              head_valid, take, eng_busy, eng_done, is_local;
    logic [DATA_W-1:0] local_word;
    cpl_t              eng_cpl, cpl_q;
    logic              cpl_v;

    always_comb begin
        in_req       = '0;
        in_req.wr    = req_write;
        in_req.ofs   = req_offset;
        in_req.len   = req_len;
        in_req.tag   = req_tag;
        in_req.wdata = req_wdata;
    end

    mmio_req_fifo #(.DEPTH(FIFO_DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push_valid (req_valid),
        .push_ready (req_ready),
        .push_data  (in_req),
        .pop_valid  (head_valid),
        .pop_ready  (take),
        .pop_data   (head)
    );

    mmio_id_window #(.LIMIT(LOCAL_LIMIT)) u_window (
        .ofs  (head.ofs),
        .len  (head.len),
        .hit  (is_local),
        .word (local_word)
    );

    // Serve the head only when nothing is in flight and the slot is empty.
    assign take = head_valid && !eng_busy && !cpl_v;

    mmio_axil_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (take && !is_local),
        .start_req (head),
        .busy      (eng_busy),
        .done      (eng_done),
        .done_cpl  (eng_cpl),
        .m_awaddr  (m_awaddr),
        .m_awprot  (m_awprot),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_bresp   (m_bresp),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_araddr  (m_araddr),
        .m_arprot  (m_arprot),
        .m_arvalid (m_arvalid),
        .m_arready (m_arready),
        .m_rdata   (m_rdata),
        .m_rresp   (m_rresp),
        .m_rvalid  (m_rvalid),
        .m_rready  (m_rready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpl_v <= 1'b0;
            cpl_q <= '0;
        end else begin
            if (cpl_v && cpl_ready) cpl_v <= 1'b0;
            if (take && is_local) begin
                cpl_v      <= 1'b1;
                cpl_q.wr   <= head.wr;
                cpl_q.tag  <= head.tag;
                cpl_q.data <= head.wr ? '0 : local_word;
                cpl_q.resp <= '0;
            end else if (eng_done) begin
                cpl_v <= 1'b1;
                cpl_q <= eng_cpl;
            end
        end
    end

    assign cpl_valid = cpl_v;
    assign cpl_write = cpl_q.wr;
    assign cpl_tag   = cpl_q.tag;
    assign cpl_data  = cpl_q.data;
    assign cpl_resp  = cpl_q.resp;

endmodule

// File: rtl/mmio_bridge_checker.sv
module mmio_bridge_checker
    import mmio_bridge_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic              cpl_write,
    input logic [TAG_W-1:0]  cpl_tag,
    input logic [DATA_W-1:0] cpl_data,
    input logic [RESP_W-1:0] cpl_resp,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [OFS_W-1:0]  m_araddr,
    input logic [PROT_W-1:0] m_arprot,
    input logic              m_rready,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [PROT_W-1:0] m_awprot,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic [STRB_W-1:0] m_wstrb,
    input logic              m_bready
);
    assert_cpl_hold_R8: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_ready |=> cpl_valid &&
            $stable({cpl_write, cpl_tag, cpl_data, cpl_resp}));

    assert_single_txn_R7: assert property (@(posedge clk) disable iff (rst)
        !((m_arvalid || m_rready) && (m_awvalid || m_wvalid || m_bready)));

    assert_ar_hold_R5: assert property (@(posedge clk) disable iff (rst)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

    assert_ar_drop_R5: assert property (@(posedge clk) disable iff (rst)
        m_arvalid && m_arready |=> !m_arvalid);

    assert_ar_rready_R5: assert property (@(posedge clk) disable iff (rst)
        m_arvalid |-> m_rready && m_arprot == '0);

    assert_aw_drop_R6: assert property (@(posedge clk) disable iff (rst)
        m_awvalid && m_awready |=> !m_awvalid);

    assert_w_drop_R6: assert property (@(posedge clk) disable iff (rst)
        m_wvalid && m_wready |=> !m_wvalid);

    assert_w_fields_R6: assert property (@(posedge clk) disable iff (rst)
        m_wvalid |-> m_wstrb == '1);

    assert_aw_prot_R6: assert property (@(posedge clk) disable iff (rst)
        m_awvalid |-> m_awprot == '0);

    assert_bready_late_R6: assert property (@(posedge clk) disable iff (rst)
        m_bready |-> !m_awvalid && !m_wvalid);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> !m_arvalid && !m_rready && !m_awvalid && !m_wvalid &&
                !m_bready && !cpl_valid);
endmodule

bind mmio_axil_bridge mmio_bridge_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .cpl_write (cpl_write),
    .cpl_tag   (cpl_tag),
    .cpl_data  (cpl_data),
    .cpl_resp  (cpl_resp),
    .m_arvalid (m_arvalid),
    .m_arready (m_arready),
    .m_araddr  (m_araddr),
    .m_arprot  (m_arprot),
    .m_rready  (m_rready),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_awprot  (m_awprot),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .m_wstrb   (m_wstrb),
    .m_bready  (m_bready)
);

// File: tb/tb_mmio_axil_bridge.sv
module tb_mmio_axil_bridge;
    import mmio_bridge_pkg::*;

    localparam int DEPTH = 4;
    localparam realtime HALF = 2.5ns;   // 200 MHz

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #HALF clk = ~clk;

    logic              req_valid = 0, req_ready, req_write = 0;
    logic [OFS_W-1:0]  req_offset = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              cpl_valid, cpl_ready = 0, cpl_write;
    logic [TAG_W-1:0]  cpl_tag;
    logic [DATA_W-1:0] cpl_data;
    logic [RESP_W-1:0] cpl_resp;
    logic [OFS_W-1:0]  m_awaddr, m_araddr;
    logic [PROT_W-1:0] m_awprot, m_arprot;
    logic              m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
    logic              m_awready = 0, m_wready = 0, m_bvalid = 0;
    logic              m_arready = 0, m_rvalid = 0;
    logic [DATA_W-1:0] m_wdata;
    logic [STRB_W-1:0] m_wstrb;
    logic [RESP_W-1:0] m_bresp = '0, m_rresp = '0;
    logic [DATA_W-1:0] m_rdata = '0;

    mmio_axil_bridge #(.FIFO_DEPTH(DEPTH)) dut (.*);

    typedef struct packed {
        logic              wr;
        logic [OFS_W-1:0]  ofs;
        logic [LEN_W-1:0]  len;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] wdata;
    } treq_t;

    treq_t req_todo[$];
    treq_t fwd_q[$];
    cpl_t  cpl_q[$];

    int n_checks = 0, n_fail = 0, overlap_err = 0, bready_err = 0;
    int cpl_mode = 0;     // 0 random, 1 hold low, 2 always high
    int slave_mode = 0;   // 0 random readies, 1 always ready
    logic [TAG_W-1:0] next_tag = '0;
    bit finished = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Expected values derived from the requirements.
    function automatic logic [31:0] exp_window(input logic [OFS_W-1:0] a);
        logic [31:0] v;
        v = 0;
        if (a == 24'h00) v = 32;
        if (a == 24'h04 || a == 24'h0C || a == 24'h10 || a == 24'h20) v = 1;
        if (a == 24'h08) v = 32'h43215678;
        if (a == 24'h14) v = 32'h200;
        if (a == 24'h18) v = 32'h80;
        if (a == 24'h24 || a == 24'h2C) v = 32'h80000;
        return v;
    endfunction

    function automatic logic [31:0] exp_trim(input logic [31:0] d, input logic [2:0] l);
        case (l)
            3'd1: return d & 32'h0000_00FF;
            3'd2: return d & 32'h0000_FFFF;
            3'd3: return d & 32'h00FF_FFFF;
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] slave_rdata(input logic [OFS_W-1:0] a);
        return {a[11:0], a[23:12] ^ 12'hC3A, 8'h5D};
    endfunction
    function automatic logic [1:0] slave_rresp(input logic [OFS_W-1:0] a);
        return a[3:2];
    endfunction
    function automatic logic [1:0] slave_bresp(input logic [OFS_W-1:0] a, input logic [31:0] d);
        return a[3:2] ^ d[1:0];
    endfunction

    function automatic void expect_req(input treq_t r);
        cpl_t c;
        c = '0;
        c.wr  = r.wr;
        c.tag = r.tag;
        if (r.ofs < 24'h80000) begin
            if (!r.wr) c.data = exp_trim(exp_window(r.ofs), r.len);
        end else begin
            fwd_q.push_back(r);
            if (r.wr) c.resp = slave_bresp(r.ofs, r.wdata);
            else begin
                c.data = exp_trim(slave_rdata(r.ofs), r.len);
                c.resp = slave_rresp(r.ofs);
            end
        end
        cpl_q.push_back(c);
    endfunction

    task automatic add_req(input bit wr, input logic [OFS_W-1:0] ofs,
                           input logic [2:0] len, input logic [31:0] wd);
        treq_t r;
        r.wr = wr; r.ofs = ofs; r.len = len; r.tag = next_tag; r.wdata = wd;
        next_tag = next_tag + 1'b1;
        req_todo.push_back(r);
    endtask

    // Bus model and scoreboard: sample at negedge, drive after posedge.
    initial begin
        bit req_hs, cpl_hs, ar_hs, r_hs, aw_hs, w_hs, b_hs;
        bit p_ar = 0, p_aw = 0, p_w = 0;
        bit hold = 0;
        logic [42:0] hold_val = '0;
        bit rd_have = 0, aw_have = 0, w_have = 0, wr_chk = 0;
        logic [OFS_W-1:0] rd_addr = '0, aw_addr = '0;
        logic [31:0] w_data = '0;
        int rd_dly = 0, b_dly = 0;
        forever begin
            @(negedge clk);
            if (rst) continue;
            req_hs = req_valid && req_ready;
            cpl_hs = cpl_valid && cpl_ready;
            ar_hs  = m_arvalid && m_arready;
            r_hs   = m_rvalid && m_rready;
            aw_hs  = m_awvalid && m_awready;
            w_hs   = m_wvalid && m_wready;
            b_hs   = m_bvalid && m_bready;
            if ((m_arvalid || m_rready) && (m_awvalid || m_wvalid || m_bready)) overlap_err++;
            if (m_bready && (m_awvalid || m_wvalid)) bready_err++;
            if (p_ar) check(!m_arvalid, "R5", "arvalid after handshake", 64'(m_arvalid), 0);
            if (p_aw) check(!m_awvalid, "R6", "awvalid after handshake", 64'(m_awvalid), 0);
            if (p_w)  check(!m_wvalid, "R6", "wvalid after handshake", 64'(m_wvalid), 0);
            if (hold) check(cpl_valid && {cpl_write, cpl_tag, cpl_data, cpl_resp} == hold_val,
                            "R8", "completion held", {cpl_valid, cpl_write, cpl_tag, cpl_data, cpl_resp},
                            {1'b1, hold_val});
            if (ar_hs) begin
                if (fwd_q.size() == 0) check(0, "R1", "unexpected read address", 64'(m_araddr), 0);
                else begin
                    treq_t e;
                    e = fwd_q.pop_front();
                    check(!e.wr && m_araddr == e.ofs && m_arprot == 0 && m_rready,
                          "R5", "read address phase", {m_rready, m_arprot, m_araddr},
                          {1'b1, 3'b0, e.ofs});
                end
                rd_have = 1; rd_addr = m_araddr; rd_dly = $urandom % 4;
            end
            if (aw_hs) begin
                aw_have = 1; aw_addr = m_awaddr;
                check(m_awprot == 0, "R6", "awprot", 64'(m_awprot), 0);
                if (!w_have && !w_hs)
                    check(m_wvalid, "R6", "wvalid with awvalid", 64'(m_wvalid), 1);
            end
            if (w_hs) begin
                w_have = 1; w_data = m_wdata;
                check(m_wstrb == 4'hF, "R6", "wstrb", 64'(m_wstrb), 64'hF);
            end
            if (aw_have && w_have && !wr_chk) begin
                wr_chk = 1; b_dly = $urandom % 4;
                if (fwd_q.size() == 0) check(0, "R4", "unexpected write", 64'(aw_addr), 0);
                else begin
                    treq_t e;
                    e = fwd_q.pop_front();
                    check(e.wr && aw_addr == e.ofs && w_data == e.wdata, "R6", "write phases",
                          {aw_addr, w_data}, {e.ofs, e.wdata});
                end
            end
            if (cpl_hs) begin
                if (cpl_q.size() == 0) check(0, "R7", "unexpected completion", 64'(cpl_tag), 0);
                else begin
                    cpl_t e;
                    e = cpl_q.pop_front();
                    check({cpl_write, cpl_tag, cpl_data, cpl_resp} == e, "R1",
                          "completion (R2 R3 R4 R5 R6 R7)",
                          {cpl_write, cpl_tag, cpl_data, cpl_resp}, e);
                end
            end
            hold = cpl_valid && !cpl_ready;
            hold_val = {cpl_write, cpl_tag, cpl_data, cpl_resp};
            p_ar = ar_hs; p_aw = aw_hs; p_w = w_hs;

            @(posedge clk);
            #1ns;
            if (req_hs) expect_req(req_todo.pop_front());
            if (!(req_valid && !req_hs)) begin
                req_valid = (req_todo.size() > 0) && ($urandom % 4 != 0);
                if (req_todo.size() > 0) begin
                    req_write  = req_todo[0].wr;
                    req_offset = req_todo[0].ofs;
                    req_len    = req_todo[0].len;
                    req_tag    = req_todo[0].tag;
                    req_wdata  = req_todo[0].wdata;
                end
            end
            if (r_hs) m_rvalid = 0;
            if (rd_have && !m_rvalid) begin
                if (rd_dly == 0) begin
                    m_rvalid = 1; m_rdata = slave_rdata(rd_addr);
                    m_rresp = slave_rresp(rd_addr); rd_have = 0;
                end else rd_dly--;
            end
            if (b_hs) m_bvalid = 0;
            if (wr_chk && !m_bvalid) begin
                if (b_dly == 0) begin
                    m_bvalid = 1; m_bresp = slave_bresp(aw_addr, w_data);
                    aw_have = 0; w_have = 0; wr_chk = 0;
                end else b_dly--;
            end
            m_arready = slave_mode == 1 ? 1'b1 : 1'($urandom % 2);
            m_awready = slave_mode == 1 ? 1'b1 : 1'($urandom % 2);
            m_wready  = slave_mode == 1 ? 1'b1 : 1'($urandom % 2);
            cpl_ready = cpl_mode == 1 ? 1'b0 : (cpl_mode == 2 ? 1'b1 : 1'($urandom % 2));
        end
    end

    task automatic drain();
        int n;
        n = 0;
        while ((req_todo.size() > 0 || cpl_q.size() > 0 || req_valid) && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (n >= 20000) check(0, "R7", "drain watchdog", 64'(cpl_q.size()), 0);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R7 global watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [23:0] offs [14];
        void'($urandom(32'd20240611));
        offs = '{24'h00, 24'h04, 24'h08, 24'h0C, 24'h10, 24'h14, 24'h18, 24'h20,
                 24'h24, 24'h2C, 24'h1C, 24'h30, 24'h02, 24'h7FFFC};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!cpl_valid && !m_arvalid && !m_awvalid && !m_wvalid && !m_bready && !m_rready,
              "R10", "outputs in reset", {cpl_valid, m_arvalid, m_awvalid, m_wvalid, m_bready, m_rready}, 0);
        @(posedge clk); #1ns; rst = 0;
        @(negedge clk);
        check(req_ready && !cpl_valid, "R10", "after reset", {req_ready, cpl_valid}, 2'b10);

        // R1 R2: window contents and unlisted offsets
        foreach (offs[i]) add_req(0, offs[i], 3'd4, 0);
        drain();
        // R3: every length value
        for (int l = 0; l < 8; l++) add_req(0, 24'h08, 3'(l), 0);
        for (int l = 0; l < 4; l++) add_req(0, 24'h80010, 3'(l), 0);
        drain();
        // R4: local write has no effect on later reads
        add_req(1, 24'h0C, 3'd4, 32'hDEAD_BEEF);
        add_req(1, 24'h7FFF0, 3'd4, 32'h1234_5678);
        add_req(0, 24'h0C, 3'd4, 0);
        drain();
        // R5 R6 boundary of the window
        add_req(0, 24'h80000, 3'd4, 0);
        add_req(1, 24'h80000, 3'd4, 32'hA5A5_0003);
        add_req(0, 24'h7FFFC, 3'd4, 0);
        add_req(1, 24'hFFFFFC, 3'd4, 32'h0F0F_F0F1);
        drain();
        // R9: queue full while completions are refused
        cpl_mode = 1;
        for (int i = 0; i < DEPTH + 2; i++) add_req(0, 24'h14, 3'd4, 0);
        repeat (30) @(posedge clk);
        @(negedge clk);
        check(!req_ready, "R9", "ready low when full", 64'(req_ready), 0);
        check(req_todo.size() == 1, "R9", "queued count", 64'(req_todo.size()), 1);
        cpl_mode = 0;
        drain();
        // Random mix, then back-to-back with ready sinks
        for (int pass = 0; pass < 2; pass++) begin
            cpl_mode = pass * 2; slave_mode = pass;
            for (int i = 0; i < 200; i++) begin
                logic [23:0] o;
                if ($urandom % 3 == 0) o = 24'(($urandom % 16) * 4);
                else o = (24'h80000 + 24'($urandom % 24'h780000)) & 24'hFFFFFC;
                add_req(1'($urandom % 2), o, 3'($urandom % 8), $urandom);
            end
            drain();
        end
        repeat (10) @(posedge clk);
        check(overlap_err == 0, "R7", "read/write channel overlap", 64'(overlap_err), 0);
        check(bready_err == 0, "R6", "bready before handshakes", 64'(bready_err), 0);
        check(fwd_q.size() == 0 && cpl_q.size() == 0, "R7", "all served",
              64'(fwd_q.size() + cpl_q.size()), 0);
        finished = 1;
        summary();
    end
endmodule